// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block collects the interrupt sources of a USB on-the-go core and presents them to a processor through a small 32-bit register port and one active-high interrupt line. Each transmit endpoint, receive endpoint and core event line sets a sticky bit in a raw source word. Software can inject or acknowledge bits through dedicated set and clear addresses. An enable mask has its own set and clear addresses. A read-only view shows the enabled pending sources.

The interrupt line fires once when any enabled source is pending. It then stays low until software writes the end-of-interrupt address. A handler therefore reads the masked view, acknowledges what it served, and finishes with an end-of-interrupt write. If anything is still pending at that point, the line fires again.

Top module: `usb_irq_wrap`

## Requirements
- R1: After reset the raw source word and the mask read as zero, the line is low, and the end-of-interrupt gate is open. An enabled pending source therefore raises the line without a prior end-of-interrupt write.
- R2: A high level on an event input sets its sticky bit at the next clock edge, and the bit stays set after the input falls. The bit layout is: transmit lines on bits 4:0, receive lines on bits 12:9, and core lines on bits 24:16. The top core line, the VBUS-drive change, is bit 24.
- R3: Writing to address 0x24 ORs the written ones into the source word.
- R4: Writing to address 0x28 clears the source bits written as one. An event input that is high in the same cycle keeps its bit set.
- R5: The mask is written whole at address 0x2C. Address 0x30 sets the mask bits written as one, and address 0x34 clears them.
- R6: Address 0x38 reads the source AND the mask. Writes to 0x38 change neither register.
- R7: Bits outside the layout of R2 always read zero and ignore writes. Addresses outside 0x20 to 0x3C read zero.
- R8: The line is high only while the gate is open and the masked view is non-zero. It stays high for exactly one cycle and then stays low until an end-of-interrupt write.
- R9: A write of any value to address 0x3C opens the gate. If a masked source is pending, the line rises in the cycle after that write.
- R10: Writing address 0x20 replaces the source word with the written value, keeping only defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_evt | input | 5 | Transmit endpoint event lines |
| rx_evt | input | 4 | Receive endpoint event lines |
| core_evt | input | 9 | Core event lines, top one is VBUS-drive change |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Interrupt line, active high |

## Verification
Two kinds of update can land on the same source bit in one cycle: a hardware event and a software clear. The bench provokes this by raising the VBUS-drive event in the same cycle as a clear write to address 0x28 that names bit 24. The bit must then read as set. A second collision is an end-of-interrupt write while an enabled source is still pending. Here the bench requires the line to rise right after that write and to fall one cycle later.

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap #(
  parameter int ADDR_W   = 8,
  parameter int TX_N     = 5,
  parameter int RX_N     = 4,
  parameter int RX_LSB   = 9,
  parameter int CORE_N   = 9,
  parameter int CORE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [CORE_N-1:0] core_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [31:0] VALID = ((32'd1 << TX_N) - 32'd1)
                                | (((32'd1 << RX_N) - 32'd1) << RX_LSB)
                                | (((32'd1 << CORE_N) - 32'd1) << CORE_LSB);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_SSET = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(8'h3C);

  logic [31:0] src_q, src_d, mask_q, mask_d, hw_evt, pend;
  logic        armed_q, eoi_wr;

  assign hw_evt = 32'(tx_evt) | (32'(rx_evt) << RX_LSB) | (32'(core_evt) << CORE_LSB);
  assign pend   = src_q & mask_q;
  assign eoi_wr = wr_en && (addr == A_EOI);
  assign irq    = armed_q && (pend != 32'd0);

  always_comb begin
    src_d = src_q;
    if (wr_en) begin
      case (addr)
        A_SRC:   src_d = wdata;
        A_SSET:  src_d = src_q | wdata;
        A_SCLR:  src_d = src_q & ~wdata;
        default: src_d = src_q;
      endcase
    end
    src_d = (src_d | hw_evt) & VALID;
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_en) begin
      case (addr)
        A_MSK:   mask_d = wdata;
        A_MSET:  mask_d = mask_q | wdata;
        A_MCLR:  mask_d = mask_q & ~wdata;
        default: mask_d = mask_q;
      endcase
    end
    mask_d = mask_d & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      if (eoi_wr)   armed_q <= 1'b1;
      else if (irq) armed_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_SRC:   rdata = src_q;
      A_MSK:   rdata = mask_q;
      A_PEND:  rdata = pend;
      default: rdata = 32'd0;
    endcase
  end
endmodule

module usb_irq_wrap_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        tx_evt,
  input logic [8:0]        core_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       src_q,
  input logic [31:0]       mask_q,
  input logic              armed_q,
  input logic              irq
);
  logic eoi;
  assign eoi = wr_en && (addr == ADDR_W'(8'h3C));

  p_sticky_tx0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt[0] |=> src_q[0]);
  p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt[8] && wr_en && addr == ADDR_W'(8'h28)) |=> src_q[24]);
  p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h34)) |=> ((mask_q & $past(wdata)) == 32'd0));
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi) |=> !irq);
  p_gate_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi) |=> !irq);
endmodule

bind usb_irq_wrap usb_irq_wrap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt[4:0]), .core_evt(core_evt[8:0]),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .src_q(src_q), .mask_q(mask_q),
  .armed_q(armed_q), .irq(irq)
);

// File: tb/test_usb_irq_wrap.sv
`timescale 1ns/1ps
module test_usb_irq_wrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tx_evt = '0;
  logic [3:0]  rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk = ~clk;

  usb_irq_wrap i_usb_irq_wrap (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event  sample_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  always begin
    @(sample_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr_ev(input logic [7:0] a, input logic [31:0] d,
                       input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tx_evt = t; rx_evt = r; core_evt = c;
    @(negedge clk);
    wr_en = 1'b0; tx_evt = '0; rx_evt = '0; core_evt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_ev(a, d, 5'd0, 4'd0, 9'd0);
  endtask

  task automatic pulse(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
    @(negedge clk);
    tx_evt = t; rx_evt = r; core_evt = c;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; core_evt = '0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    #1;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_rd(8'h20, 32'h0, "R1 source after reset");
    chk_rd(8'h2C, 32'h0, "R1 mask after reset");
    chk_irq(1'b0, "R1 line low after reset");

    pulse(5'h15, 4'hA, 9'h0);
    chk_irq(1'b0, "R8 no line while masked off");
    chk_rd(8'h20, 32'h0000_1415, "R2 tx/rx latched sticky");
    pulse(5'h0, 4'h0, 9'h081);
    chk_rd(8'h20, 32'h0081_1415, "R2 core lines at 24:16");

    wr(8'h24, 32'hFFFF_FFFF);
    chk_rd(8'h20, 32'h01FF_1E1F, "R3 set alias, R7 undefined bits zero");
    wr(8'h28, 32'hFFFF_FFFF);
    chk_rd(8'h20, 32'h0, "R4 clear alias");

    wr_ev(8'h28, 32'h0100_0000, 5'd0, 4'd0, 9'h100);
    chk_rd(8'h20, 32'h0100_0000, "R4 event beats same-cycle clear");

    wr(8'h2C, 32'hFFFF_FFFF);
    chk_irq(1'b1, "R1 gate open after reset, R8 line rises");
    chk_rd(8'h2C, 32'h01FF_1E1F, "R5 direct mask write, R7");
    chk_irq(1'b0, "R8 single-cycle pulse");
    chk_rd(8'h38, 32'h0100_0000, "R6 masked view");
    wr(8'h38, 32'h0000_0000);
    chk_rd(8'h38, 32'h0100_0000, "R6 write to masked view ignored");
    chk_rd(8'h2C, 32'h01FF_1E1F, "R6 mask untouched by masked-view write");

    wr(8'h34, 32'h00FF_1E1E);
    chk_rd(8'h2C, 32'h0100_0001, "R5 mask clear alias");
    wr(8'h30, 32'h0000_0002);
    chk_rd(8'h2C, 32'h0100_0003, "R5 mask set alias");

    pulse(5'h01, 4'h0, 9'h0);
    chk_irq(1'b0, "R8 held low until end-of-interrupt");
    chk_rd(8'h38, 32'h0100_0001, "R6 masked view with two sources");

    wr(8'h3C, 32'h0);
    chk_irq(1'b1, "R9 re-fire after end-of-interrupt with pending");
    @(negedge clk);
    chk_irq(1'b0, "R9 pulse ends");

    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h1234_5678);
    chk_irq(1'b0, "R9 gate open but nothing pending");
    pulse(5'h0, 4'h0, 9'h100);
    chk_irq(1'b1, "R9 armed gate fires on new event");

    wr(8'h20, 32'hFFFF_FFFF);
    chk_rd(8'h20, 32'h01FF_1E1F, "R10 direct source write, R7");
    wr(8'h20, 32'h0000_0104);
    chk_rd(8'h20, 32'h0000_0004, "R10 replace keeps defined bits only");

    chk_rd(8'h00, 32'h0, "R7 unmapped address reads zero");
    chk_rd(8'h40, 32'h0, "R7 address above map reads zero");
    chk_rd(8'h3C, 32'h0, "R7 end-of-interrupt reads zero");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule